// File: doc/BRIEF.md
# Metering Test Pulse Tally

This block counts test pulses for an energy meter. It takes one of two pulse sources: a pin driven from outside the chip, or the pulse train from an on-chip generator. The chosen source is gated by an enable and brought into the slow counting clock domain by a short flop chain. A rising-edge detector then turns every high-active pulse into a single increment of a running tally. The tally is 17 bits wide by default. When it wraps it raises a flag, and that flag stays set.

Software never reads the running tally directly. It raises a read request. On the next clock edge the block copies the low bits of the tally into a narrower holding register (16 bits by default) and raises an acknowledge. The held value stays frozen for as long as the request is held. A clear input zeroes the tally and the wrap flag at any time, including while counting is disabled. The input path has no filtering, so contact bounce must be removed outside the block.

Top module: `test_pulse_tally`

## Requirements
- R1: Each rising edge of the selected, enabled source adds exactly one to `count_o`. If the source rises just before clock edge 0, the new value is visible after clock edge 2 and not before.
- R2: `src_sel_i` = 0 selects `ext_pulse_i` and `src_sel_i` = 1 selects `gen_pulse_i`. Pulses on the other input leave the count unchanged.
- R3: The tally is CNT_W bits wide (default 17). An increment from the all-ones value gives zero and sets `ovf_o`.
- R4: `ovf_o` stays set through later increments until a clear.
- R5: A clear on a clock edge sets `count_o` and `ovf_o` to zero whatever the state of `count_en_i`. If an increment falls on the same edge, the clear wins.
- R6: While `count_en_i` is low, pulses do not count. Because the enable gates the source ahead of the synchronizer, raising the enable while the selected source is already high adds one count.
- R7: If `rd_req_i` is high at a clock edge while `rd_ack_o` is low, that edge loads `rd_data_o` with the low SNAP_W bits (default 16) of the tally as it stood before that edge, and raises `rd_ack_o`.
- R8: While `rd_req_i` stays high, `rd_ack_o` stays high and `rd_data_o` does not change. `rd_ack_o` falls at the first edge at which `rd_req_i` is low. A new snapshot needs the request to go low and then high again.
- R9: After reset, `count_o`, `ovf_o`, `rd_ack_o` and `rd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (low-frequency domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pulse_i | input | 1 | Pulse input from outside the chip, unfiltered |
| gen_pulse_i | input | 1 | Pulse output of the on-chip generator |
| src_sel_i | input | 1 | Source select: 0 external, 1 generator |
| count_en_i | input | 1 | Counting enable, gates the source ahead of the synchronizer |
| clear_i | input | 1 | Synchronous clear of tally and wrap flag |
| rd_req_i | input | 1 | Snapshot read request |
| count_o | output | CNT_W | Running tally |
| ovf_o | output | 1 | Sticky wrap flag |
| rd_ack_o | output | 1 | Snapshot read acknowledge |
| rd_data_o | output | SNAP_W | Snapshot of the low tally bits |

## Verification
Two pairs of events can land on the same clock edge: an increment with a clear, and an increment with a snapshot load. To create each collision, the bench raises the source at a falling edge. It then asserts the clear or the read request two falling edges later, so that the request lands on the third rising edge, the one on which the increment arrives. For the clear, the bench expects a zero tally that stays at zero once the source is released. For the snapshot, it expects the held value to show the tally from before the increment while the running tally has already moved one higher.

// File: rtl/tally_pkg.sv
package tally_pkg;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_GEN = 1'b1
    } tally_src_e;

    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;

endpackage

// File: rtl/tally_front.sv
module tally_front
    import tally_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic gen_i,
    input  logic sel_i,
    input  logic en_i,
    output logic sync_o
);

    localparam int LAST = SYNC_STAGES - 1;

    tally_src_e src;
    logic       picked;
    logic       gated;

    logic [SYNC_STAGES-1:0] chain_d, chain_q;

    always_comb begin
        src    = tally_src_e'(sel_i);
        picked = (src == SRC_GEN) ? gen_i : ext_i;
        // enable gates ahead of the synchronizer: re-enabling on a high level yields an edge
        gated  = picked & en_i;
    end

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign chain_d[i] = gated;
        end else begin : g_next
            assign chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];

    assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !chain_q[0]);

endmodule

// File: rtl/tally_edge.sv
module tally_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sync_i;
        rise_o = sync_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tally_core.sv
module tally_core #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_TOP) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign ovf_o   = st_q.ovf;

    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0) && !ovf_o);

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && inc_i) |=> count_o == $past(count_o) + 1'b1);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !inc_i) |=> $stable(count_o));

    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && inc_i && count_o == CNT_TOP) |=> ovf_o);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clear_i) |=> ovf_o);

endmodule

// File: rtl/tally_snap.sv
module tally_snap
    import tally_pkg::*;
#(
    parameter int CNT_W  = 17,
    parameter int SNAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              req_i,
    output logic              ack_o,
    output logic [SNAP_W-1:0] data_o
);

    typedef struct packed {
        snap_state_e       state;
        logic [SNAP_W-1:0] data;
    } snap_t;

    snap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            SNAP_IDLE: if (req_i) begin
                st_d.data  = count_i[SNAP_W-1:0];
                st_d.state = SNAP_HELD;
            end
            SNAP_HELD: if (!req_i) st_d.state = SNAP_IDLE;
            default:   st_d.state = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: SNAP_IDLE, data: '0};
        else        st_q <= st_d;
    end

    assign ack_o  = (st_q.state == SNAP_HELD);
    assign data_o = st_q.data;

    assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_i));

    assert_load_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ack_o) |=> data_o == $past(count_i[SNAP_W-1:0]));

    assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_i) |=> ack_o && $stable(data_o));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_i) |=> !ack_o);

endmodule

// File: rtl/test_pulse_tally.sv
module test_pulse_tally #(
    parameter int CNT_W       = 17,
    parameter int SNAP_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pulse_i,
    input  logic              gen_pulse_i,
    input  logic              src_sel_i,
    input  logic              count_en_i,
    input  logic              clear_i,
    input  logic              rd_req_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o,
    output logic              rd_ack_o,
    output logic [SNAP_W-1:0] rd_data_o
);

    logic synced;
    logic rise;

    tally_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_i  (ext_pulse_i),
        .gen_i  (gen_pulse_i),
        .sel_i  (src_sel_i),
        .en_i   (count_en_i),
        .sync_o (synced)
    );

    tally_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (synced),
        .rise_o (rise)
    );

    tally_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (rise),
        .clear_i (clear_i),
        .count_o (count_o),
        .ovf_o   (ovf_o)
    );

    tally_snap #(.CNT_W(CNT_W), .SNAP_W(SNAP_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (count_o),
        .req_i   (rd_req_i),
        .ack_o   (rd_ack_o),
        .data_o  (rd_data_o)
    );

endmodule

// File: tb/tb_test_pulse_tally.sv
module tb_test_pulse_tally;

    localparam int CW = 9;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_pulse = 1'b0, gen_pulse = 1'b0, src_sel = 1'b0;
    logic          count_en = 1'b1, clear = 1'b0, rd_req = 1'b0;
    logic [CW-1:0] count;
    logic          ovf, rd_ack;
    logic [SW-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    test_pulse_tally #(.CNT_W(CW), .SNAP_W(SW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .ext_pulse_i(ext_pulse), .gen_pulse_i(gen_pulse),
        .src_sel_i(src_sel), .count_en_i(count_en), .clear_i(clear), .rd_req_i(rd_req),
        .count_o(count), .ovf_o(ovf), .rd_ack_o(rd_ack), .rd_data_o(rd_data)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit use_gen);
        if (use_gen) gen_pulse = 1'b1; else ext_pulse = 1'b1;
        waitn(2);
        if (use_gen) gen_pulse = 1'b0; else ext_pulse = 1'b0;
        waitn(2);
    endtask

    task automatic do_clear();
        clear = 1'b1; waitn(1); clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R9", "count", count, 0);
        check("R9", "ovf", ovf, 0);
        check("R9", "ack", rd_ack, 0);
        check("R9", "data", rd_data, 0);
    endtask

    task automatic t_count_ext();
        do_clear();
        src_sel = 1'b0;
        ext_pulse = 1'b1; waitn(2);
        check("R1", "count before 3rd edge", count, 0);
        waitn(1);
        check("R1", "count after 3rd edge", count, 1);
        ext_pulse = 1'b0; waitn(3);
        pulse(1'b0); pulse(1'b0);
        check("R1", "count after three pulses", count, 3);
    endtask

    task automatic t_select();
        do_clear();
        src_sel = 1'b0;
        pulse(1'b1);
        check("R2", "gen ignored when ext chosen", count, 0);
        pulse(1'b0);
        check("R2", "ext counted", count, 1);
        src_sel = 1'b1; waitn(3);
        pulse(1'b0);
        check("R2", "ext ignored when gen chosen", count, 1);
        pulse(1'b1); pulse(1'b1);
        check("R2", "gen counted", count, 3);
        src_sel = 1'b0; waitn(3);
    endtask

    task automatic t_enable();
        do_clear();
        count_en = 1'b0; waitn(3);
        pulse(1'b0);
        check("R6", "pulse while disabled", count, 0);
        ext_pulse = 1'b1; waitn(4);
        check("R6", "high level while disabled", count, 0);
        count_en = 1'b1; waitn(3);
        check("R6", "enable on high level adds one", count, 1);
        ext_pulse = 1'b0; waitn(3);
        count_en = 1'b0; waitn(3);
        count_en = 1'b1; waitn(3);
        check("R6", "toggle with low input", count, 1);
    endtask

    task automatic t_clear_disabled();
        pulse(1'b0);
        count_en = 1'b0; waitn(1);
        do_clear(); waitn(1);
        check("R5", "clear while disabled", count, 0);
        count_en = 1'b1; waitn(3);
    endtask

    task automatic t_clear_collision();
        do_clear();
        pulse(1'b0); pulse(1'b0);
        ext_pulse = 1'b1; waitn(2);
        clear = 1'b1; waitn(1); clear = 1'b0;
        check("R5", "clear beats increment", count, 0);
        ext_pulse = 1'b0; waitn(3);
        check("R5", "no late increment", count, 0);
    endtask

    task automatic t_read();
        do_clear();
        for (int i = 0; i < 5; i++) pulse(1'b0);
        rd_req = 1'b1; waitn(1);
        check("R7", "ack raised", rd_ack, 1);
        check("R7", "snapshot value", rd_data, 5);
        pulse(1'b0); pulse(1'b0);
        check("R8", "snapshot frozen", rd_data, 5);
        check("R8", "ack held", rd_ack, 1);
        check("R8", "count moved on", count, 7);
        rd_req = 1'b0; waitn(1);
        check("R8", "ack dropped", rd_ack, 0);
        rd_req = 1'b1; waitn(1);
        check("R8", "fresh snapshot", rd_data, 7);
        rd_req = 1'b0; waitn(1);
    endtask

    task automatic t_snap_collision();
        do_clear();
        for (int i = 0; i < 4; i++) pulse(1'b0);
        ext_pulse = 1'b1; waitn(2);
        rd_req = 1'b1; waitn(1);
        check("R7", "snapshot holds pre-increment value", rd_data, 4);
        check("R7", "count incremented same edge", count, 5);
        ext_pulse = 1'b0; rd_req = 1'b0; waitn(3);
    endtask

    task automatic t_overflow();
        do_clear();
        for (int i = 0; i < 300; i++) pulse(1'b0);
        rd_req = 1'b1; waitn(1);
        check("R7", "snapshot keeps low bits", rd_data, 300 % 256);
        rd_req = 1'b0; waitn(1);
        for (int i = 300; i < 511; i++) pulse(1'b0);
        check("R3", "count at top", count, 511);
        check("R3", "no flag before wrap", ovf, 0);
        pulse(1'b0);
        check("R3", "wrapped to zero", count, 0);
        check("R3", "flag on wrap", ovf, 1);
        pulse(1'b0);
        check("R4", "flag sticky", ovf, 1);
        check("R4", "count after wrap", count, 1);
        do_clear();
        check("R4", "flag cleared", ovf, 0);
        check("R5", "count cleared", count, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        waitn(3);
        t_reset();
        rst_n = 1'b1;
        waitn(2);
        t_count_ext();
        t_select();
        t_enable();
        t_clear_disabled();
        t_clear_collision();
        t_read();
        t_snap_collision();
        t_overflow();
        finish_run();
    end

endmodule